// File: doc/BRIEF.md
# Data Cache Line State Controller

This block keeps the coherence state and the contents of a single data cache line. It also runs the memory transfers that each write-side or maintenance command needs. A command arrives with an operation code, a copy-back or write-through mode bit, and a policy bit that applies to push commands. It also carries the word index and word data that a write touches. Memory reads fill a whole line. Memory writes carry either a full line or a single word, and a per-word mask tells them apart.

A dirty line that a copy-back write miss displaces is first saved into a one-line holding buffer. The new line is then fetched and merged with the write data. The saved line is written back last. A push command either invalidates the line or keeps it resident and clean, depending on the policy bit. The controller raises busy while transfers are outstanding and pulses done once per command.

Top module: `dcl_line_ctrl`

## Requirements
- R1: The line state is shown as `line_valid`/`line_mod`. Invalid is 0/0, clean valid is 1/0 and modified is 1/1. `line_mod` is never high while `line_valid` is low. After reset the line is invalid, and busy, done, err, fill_req and mem_wr_valid are all low.
- R2: Op code 0 is write miss. A copy-back write miss (`cmd_copyback`=1) on an invalid or clean line does one fill. The fetched line takes the write word at index `cmd_idx`, where word i occupies bits [8i+7:8i] at the default width. The line ends modified and no memory write is made.
- R3: A copy-back write miss on a modified line saves the old line, then does one fill, then writes the old line to memory with all mask bits set. The fill handshake comes before the write handshake. The line ends modified and holds the merged new data.
- R4: A write-through write miss makes one memory write and no fill. The write puts `cmd_wdata` in word `cmd_idx` with the other words zero, and the mask has only bit `cmd_idx` set. The line state and data are unchanged.
- R5: Op code 1 is write hit. A copy-back write hit on a valid line merges the word into the line and sets it modified. It makes no memory traffic and done is high in the cycle after acceptance.
- R6: A write-through write hit on a valid line makes one single-word memory write, in the same form as R4. It merges the word into the line and leaves the line clean valid, even if it was modified before.
- R7: Op code 2 is invalidate. It makes no memory traffic and leaves the line invalid, and any dirty data is dropped.
- R8: Op code 3 is push. With `cmd_keep`=0, a modified line is written to memory as a full line and becomes invalid. A clean line becomes invalid with no traffic, and an invalid line stays invalid.
- R9: A push with `cmd_keep`=1 writes a modified line to memory as a full line and leaves it clean valid. A clean line stays valid and an invalid line stays invalid, and neither case makes any traffic.
- R10: A write hit on an invalid line pulses err together with done. It makes no memory traffic and leaves the state invalid.
- R11: `fill_req` stays high until `fill_ack`. `mem_wr_valid`, data and mask stay steady until `mem_wr_ready`. `cmd_ready` is low while a transfer is pending. Done pulses for exactly one cycle, in the cycle after the last handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Controller can take a command (not busy) |
| cmd_op | input | 2 | 0 write miss, 1 write hit, 2 invalidate, 3 push |
| cmd_copyback | input | 1 | 1 copy-back, 0 write-through |
| cmd_keep | input | 1 | Push policy: 1 keep line valid, 0 invalidate |
| cmd_idx | input | IDX_W | Word index of the write |
| cmd_wdata | input | WORD_W | Write word |
| fill_req | output | 1 | Line fill request |
| fill_ack | input | 1 | Fill accepted, fill_data valid |
| fill_data | input | LINE_W | Fetched line |
| mem_wr_valid | output | 1 | Memory write request |
| mem_wr_ready | input | 1 | Memory write accepted |
| mem_wr_data | output | LINE_W | Write data |
| mem_wr_mask | output | WORDS | Per-word write enable |
| line_valid | output | 1 | Line valid bit |
| line_mod | output | 1 | Line modified bit |
| line_data | output | LINE_W | Line contents |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Illegal write hit on an invalid line |

## Verification
The bench uses the default 8-bit words and four words per line. This keeps every word index small enough to sweep in full for each command. It visits every prior state (invalid, clean, modified) with every op code, both mode bits, both policy bits and all four indices. It varies the handshake stalls from zero to two cycles, which checks that requests are held under back-pressure and that the fill comes before the write-back on a dirty miss.

// File: rtl/dcl_pkg.sv
// Shared types for the data cache line controller.
package dcl_pkg;
    typedef enum logic [1:0] {
        OP_WMISS = 2'd0,
        OP_WHIT  = 2'd1,
        OP_INVAL = 2'd2,
        OP_PUSH  = 2'd3
    } dcl_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_FILL   = 2'd1,
        ST_WORDWR = 2'd2,
        ST_LINEWR = 2'd3
    } dcl_st_e;
endpackage

// File: rtl/dcl_word_merge.sv
// Replaces one word of a line with a new word and produces the one-hot
// word mask. Purely combinational. Assumes WORDS >= 2.
module dcl_word_merge #(
    parameter int WORD_W = 8,
    parameter int WORDS  = 4,
    localparam int LINE_W = WORD_W * WORDS,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic [LINE_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0] word,
    output logic [LINE_W-1:0] merged,
    output logic [WORDS-1:0]  mask
);
    for (genvar g = 0; g < WORDS; g++) begin : g_word
        // select the new word in the indexed slot, else keep the base word
        assign merged[g*WORD_W +: WORD_W] = (idx == IDX_W'(g)) ? word
                                          : base[g*WORD_W +: WORD_W];
        assign mask[g] = (idx == IDX_W'(g));
    end
endmodule

// File: rtl/dcl_line_store.sv
// Holds the valid and modified bits and the data of the line.
// Assumes the sequencer never asks for modified without valid.
module dcl_line_store #(
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              upd_v,
    input  logic              upd_m,
    input  logic              upd_data_en,
    input  logic [LINE_W-1:0] upd_data,
    output logic              valid,
    output logic              mod,
    output logic [LINE_W-1:0] data
);
    // state bits: reset to invalid, load on update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            mod   <= 1'b0;
        end else if (upd_en) begin
            valid <= upd_v;
            mod   <= upd_m;
        end
    end

    // line contents: written only when data is supplied
    always_ff @(posedge clk) begin
        if (!rst_n)
            data <= '0;
        else if (upd_en && upd_data_en)
            data <= upd_data;
    end
endmodule

// File: rtl/dcl_push_buf.sv
// One-line holding register for a dirty line on its way to memory.
// Assumes load is never raised while its contents are still being written.
module dcl_push_buf #(
    parameter int LINE_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [LINE_W-1:0] din,
    output logic [LINE_W-1:0] dout
);
    // capture the line on load
    always_ff @(posedge clk) begin
        if (!rst_n)
            dout <= '0;
        else if (load)
            dout <= din;
    end
endmodule

// File: rtl/dcl_seq.sv
// Command sequencer. Decodes each command against the current line state,
// steps through fill / word write / line write, and drives the line-store
// updates. Assumes commands are offered only while idle.
module dcl_seq
    import dcl_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int WORDS  = 4,
    localparam int LINE_W = WORD_W * WORDS,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  dcl_op_e           cmd_op,
    input  logic              cmd_cb,
    input  logic              cmd_keep,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [WORD_W-1:0] cmd_wdata,
    input  logic              line_valid,
    input  logic              line_mod,
    input  logic [LINE_W-1:0] line_data,
    input  logic              fill_ack,
    input  logic [LINE_W-1:0] fill_data,
    input  logic              mem_wr_ready,
    input  logic [LINE_W-1:0] pbuf_data,
    output logic              fill_req,
    output logic              mem_wr_valid,
    output logic [LINE_W-1:0] mem_wr_data,
    output logic [WORDS-1:0]  mem_wr_mask,
    output logic              upd_en,
    output logic              upd_v,
    output logic              upd_m,
    output logic              upd_data_en,
    output logic [LINE_W-1:0] upd_data,
    output logic              pb_load,
    output logic              busy,
    output logic              done,
    output logic              err
);
    dcl_st_e           st, st_n;
    dcl_op_e           lat_op;
    logic [IDX_W-1:0]  lat_idx;
    logic [WORD_W-1:0] lat_w;
    logic              lat_keep, lat_dirty;
    logic              done_n, err_n;
    logic [IDX_W-1:0]  sel_idx;
    logic [WORD_W-1:0] sel_w;
    logic [LINE_W-1:0] merge_base, merged, word_only;
    logic [WORDS-1:0]  word_mask, word_mask_unused;

    // pick the live command fields while idle, the latched ones later
    always_comb begin
        sel_idx    = (st == ST_IDLE) ? cmd_idx   : lat_idx;
        sel_w      = (st == ST_IDLE) ? cmd_wdata : lat_w;
        merge_base = (st == ST_FILL) ? fill_data : line_data;
    end

    dcl_word_merge #(.WORD_W(WORD_W), .WORDS(WORDS)) u_merge (
        .base(merge_base), .idx(sel_idx), .word(sel_w),
        .merged(merged), .mask(word_mask_unused)
    );

    dcl_word_merge #(.WORD_W(WORD_W), .WORDS(WORDS)) u_wordonly (
        .base('0), .idx(lat_idx), .word(lat_w),
        .merged(word_only), .mask(word_mask)
    );

    // memory-side request outputs follow the state
    always_comb begin
        fill_req     = (st == ST_FILL);
        mem_wr_valid = (st == ST_WORDWR) || (st == ST_LINEWR);
        mem_wr_data  = (st == ST_LINEWR) ? pbuf_data : word_only;
        mem_wr_mask  = (st == ST_LINEWR) ? {WORDS{1'b1}} : word_mask;
        busy         = (st != ST_IDLE);
        upd_data     = merged;
    end

    // next-state and line-update decode
    always_comb begin
        st_n        = st;
        upd_en      = 1'b0;
        upd_v       = line_valid;
        upd_m       = line_mod;
        upd_data_en = 1'b0;
        pb_load     = 1'b0;
        done_n      = 1'b0;
        err_n       = 1'b0;
        case (st)
            ST_IDLE: if (cmd_valid) begin
                case (cmd_op)
                    OP_WMISS: begin
                        if (cmd_cb) begin
                            st_n    = ST_FILL;
                            pb_load = line_mod;
                        end else begin
                            st_n = ST_WORDWR;
                        end
                    end
                    OP_WHIT: begin
                        if (!line_valid) begin
                            done_n = 1'b1;
                            err_n  = 1'b1;
                        end else if (cmd_cb) begin
                            upd_en      = 1'b1;
                            upd_v       = 1'b1;
                            upd_m       = 1'b1;
                            upd_data_en = 1'b1;
                            done_n      = 1'b1;
                        end else begin
                            st_n = ST_WORDWR;
                        end
                    end
                    OP_INVAL: begin
                        upd_en = 1'b1;
                        upd_v  = 1'b0;
                        upd_m  = 1'b0;
                        done_n = 1'b1;
                    end
                    default: begin
                        if (line_mod) begin
                            pb_load = 1'b1;
                            st_n    = ST_LINEWR;
                        end else begin
                            upd_en = 1'b1;
                            upd_v  = line_valid & cmd_keep;
                            upd_m  = 1'b0;
                            done_n = 1'b1;
                        end
                    end
                endcase
            end
            ST_FILL: if (fill_ack) begin
                upd_en      = 1'b1;
                upd_v       = 1'b1;
                upd_m       = 1'b1;
                upd_data_en = 1'b1;
                if (lat_dirty) begin
                    st_n = ST_LINEWR;
                end else begin
                    st_n   = ST_IDLE;
                    done_n = 1'b1;
                end
            end
            ST_WORDWR: if (mem_wr_ready) begin
                st_n   = ST_IDLE;
                done_n = 1'b1;
                if (lat_op == OP_WHIT) begin
                    upd_en      = 1'b1;
                    upd_v       = 1'b1;
                    upd_m       = 1'b0;
                    upd_data_en = 1'b1;
                end
            end
            default: if (mem_wr_ready) begin
                st_n   = ST_IDLE;
                done_n = 1'b1;
                if (lat_op == OP_PUSH) begin
                    upd_en = 1'b1;
                    upd_v  = lat_keep;
                    upd_m  = 1'b0;
                end
            end
        endcase
    end

    // state, completion flags and latched command fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= ST_IDLE;
            done      <= 1'b0;
            err       <= 1'b0;
            lat_op    <= OP_WMISS;
            lat_idx   <= '0;
            lat_w     <= '0;
            lat_keep  <= 1'b0;
            lat_dirty <= 1'b0;
        end else begin
            st   <= st_n;
            done <= done_n;
            err  <= err_n;
            if (st == ST_IDLE && cmd_valid) begin
                lat_op    <= cmd_op;
                lat_idx   <= cmd_idx;
                lat_w     <= cmd_wdata;
                lat_keep  <= cmd_keep;
                lat_dirty <= line_mod;
            end
        end
    end

    // R3
    dirty_fill_then_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FILL && fill_ack && lat_dirty) |=> (st == ST_LINEWR));
endmodule

// File: rtl/dcl_line_ctrl.sv
// Top of the data cache line controller: line store, holding buffer and
// sequencer. Assumes memory returns a full line per fill and accepts one
// write per handshake.
module dcl_line_ctrl
    import dcl_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int WORDS  = 4,
    localparam int LINE_W = WORD_W * WORDS,
    localparam int IDX_W  = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic              cmd_copyback,
    input  logic              cmd_keep,
    input  logic [IDX_W-1:0]  cmd_idx,
    input  logic [WORD_W-1:0] cmd_wdata,
    output logic              fill_req,
    input  logic              fill_ack,
    input  logic [LINE_W-1:0] fill_data,
    output logic              mem_wr_valid,
    input  logic              mem_wr_ready,
    output logic [LINE_W-1:0] mem_wr_data,
    output logic [WORDS-1:0]  mem_wr_mask,
    output logic              line_valid,
    output logic              line_mod,
    output logic [LINE_W-1:0] line_data,
    output logic              busy,
    output logic              done,
    output logic              err
);
    logic              upd_en, upd_v, upd_m, upd_data_en, pb_load;
    logic [LINE_W-1:0] upd_data, pbuf_data;
    logic              acc;

    dcl_line_store #(.LINE_W(LINE_W)) u_store (
        .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .upd_v(upd_v), .upd_m(upd_m),
        .upd_data_en(upd_data_en), .upd_data(upd_data),
        .valid(line_valid), .mod(line_mod), .data(line_data)
    );

    dcl_push_buf #(.LINE_W(LINE_W)) u_pbuf (
        .clk(clk), .rst_n(rst_n), .load(pb_load), .din(line_data), .dout(pbuf_data)
    );

    dcl_seq #(.WORD_W(WORD_W), .WORDS(WORDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(dcl_op_e'(cmd_op)),
        .cmd_cb(cmd_copyback), .cmd_keep(cmd_keep), .cmd_idx(cmd_idx),
        .cmd_wdata(cmd_wdata), .line_valid(line_valid), .line_mod(line_mod),
        .line_data(line_data), .fill_ack(fill_ack), .fill_data(fill_data),
        .mem_wr_ready(mem_wr_ready), .pbuf_data(pbuf_data), .fill_req(fill_req),
        .mem_wr_valid(mem_wr_valid), .mem_wr_data(mem_wr_data),
        .mem_wr_mask(mem_wr_mask), .upd_en(upd_en), .upd_v(upd_v), .upd_m(upd_m),
        .upd_data_en(upd_data_en), .upd_data(upd_data), .pb_load(pb_load),
        .busy(busy), .done(done), .err(err)
    );

    // command handshake
    always_comb begin
        cmd_ready = !busy;
        acc       = cmd_valid && cmd_ready;
    end

    // R1
    mod_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_mod |-> line_valid);
    // R11
    fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_req && !fill_ack) |=> fill_req);
    // R11
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=>
            (mem_wr_valid && $stable(mem_wr_data) && $stable(mem_wr_mask)));
    // R11
    single_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fill_req && mem_wr_valid));
    // R7
    inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd2) |=> (!line_valid && !fill_req && !mem_wr_valid && done));
    // R10
    bad_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd1 && !line_valid) |=> (err && done && !line_valid && !busy));
    // R5
    cb_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && cmd_op == 2'd1 && cmd_copyback && line_valid) |=> (line_mod && done && !busy));
endmodule

// File: tb/dcl_line_ctrl_test.sv
module dcl_line_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [1:0]  cmd_op = '0;
    logic        cmd_copyback = 1'b0;
    logic        cmd_keep = 1'b0;
    logic [1:0]  cmd_idx = '0;
    logic [7:0]  cmd_wdata = '0;
    logic        fill_req;
    logic        fill_ack = 1'b0;
    logic [31:0] fill_data = '0;
    logic        mem_wr_valid;
    logic        mem_wr_ready = 1'b0;
    logic [31:0] mem_wr_data;
    logic [3:0]  mem_wr_mask;
    logic        line_valid, line_mod;
    logic [31:0] line_data;
    logic        busy, done, err;

    int ncmp = 0;
    int nbad = 0;
    int tnum = 0;
    bit finished = 0;

    // model of the line
    logic        mv = 0, mm = 0;
    logic [31:0] md = '0;

    always #4 clk = ~clk;

    dcl_line_ctrl #(.WORD_W(8), .WORDS(4)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_copyback(cmd_copyback), .cmd_keep(cmd_keep),
        .cmd_idx(cmd_idx), .cmd_wdata(cmd_wdata), .fill_req(fill_req),
        .fill_ack(fill_ack), .fill_data(fill_data), .mem_wr_valid(mem_wr_valid),
        .mem_wr_ready(mem_wr_ready), .mem_wr_data(mem_wr_data),
        .mem_wr_mask(mem_wr_mask), .line_valid(line_valid), .line_mod(line_mod),
        .line_data(line_data), .busy(busy), .done(done), .err(err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        ncmp++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] mrg(input logic [31:0] b, input logic [1:0] i,
                                        input logic [7:0] w);
        logic [31:0] r;
        r = b;
        r[i*8 +: 8] = w;
        return r;
    endfunction

    task automatic run_cmd(input logic [1:0] op, input logic cb, input logic keep,
                           input logic [1:0] idx, input logic [7:0] w, input int stall);
        string tag;
        logic [31:0] fv, exp_wd, nd, wd, first_wd;
        logic [3:0]  exp_wm, wm, first_wm;
        int exp_fill, exp_wr, nfill, nwr, fill_at, wr_at, cyc, stc;
        logic exp_err, nv, nm, seen_err, got_done, wr_seen;
        tnum++;
        fv = 32'hC3A50000 ^ (tnum * 32'h01030507);
        exp_fill = 0; exp_wr = 0; exp_wd = '0; exp_wm = '0; exp_err = 0;
        nv = mv; nm = mm; nd = md;
        case (op)
            2'd0: if (cb) begin
                tag = mm ? "R3" : "R2";
                exp_fill = 1;
                if (mm) begin exp_wr = 1; exp_wd = md; exp_wm = 4'hF; end
                nv = 1; nm = 1; nd = mrg(fv, idx, w);
            end else begin
                tag = "R4";
                exp_wr = 1; exp_wd = mrg('0, idx, w); exp_wm = 4'b1 << idx;
            end
            2'd1: if (!mv) begin
                tag = "R10"; exp_err = 1;
            end else if (cb) begin
                tag = "R5"; nm = 1; nd = mrg(md, idx, w);
            end else begin
                tag = "R6"; exp_wr = 1; exp_wd = mrg('0, idx, w); exp_wm = 4'b1 << idx;
                nm = 0; nd = mrg(md, idx, w);
            end
            2'd2: begin tag = "R7"; nv = 0; nm = 0; end
            default: begin
                tag = keep ? "R9" : "R8";
                if (mm) begin exp_wr = 1; exp_wd = md; exp_wm = 4'hF; end
                nv = mv & keep; nm = 0;
            end
        endcase

        @(negedge clk);
        chk("R11", "cmd_ready idle", {31'b0, cmd_ready}, 32'd1);
        cmd_valid = 1; cmd_op = op; cmd_copyback = cb; cmd_keep = keep;
        cmd_idx = idx; cmd_wdata = w;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 0;
        nfill = 0; nwr = 0; fill_at = -1; wr_at = -1; cyc = 0; stc = 0;
        got_done = 0; seen_err = 0; wr_seen = 0; wd = '0; wm = '0;
        first_wd = '0; first_wm = '0;
        while (!got_done && cyc < 60) begin
            if (done) begin
                got_done = 1;
                seen_err = err;
            end else begin
                if (cmd_ready) chk("R11", "cmd_ready while busy", 32'd1, 32'd0);
                if (fill_req) begin
                    if (stc >= stall) begin
                        fill_ack = 1; fill_data = fv; nfill++; fill_at = cyc; stc = 0;
                    end else stc++;
                end else if (mem_wr_valid) begin
                    if (!wr_seen) begin
                        wr_seen = 1; first_wd = mem_wr_data; first_wm = mem_wr_mask;
                    end else if (mem_wr_data !== first_wd || mem_wr_mask !== first_wm) begin
                        chk("R11", "write held steady", mem_wr_data, first_wd);
                    end
                    if (stc >= stall) begin
                        mem_wr_ready = 1; nwr++; wr_at = cyc; wd = mem_wr_data;
                        wm = mem_wr_mask; stc = 0; wr_seen = 0;
                    end else stc++;
                end
                @(posedge clk);
                @(negedge clk);
                fill_ack = 0; mem_wr_ready = 0;
                cyc++;
            end
        end
        chk("R11", "done seen", {31'b0, got_done}, 32'd1);
        chk(tag, "err", {31'b0, seen_err}, {31'b0, exp_err});
        chk(tag, "fill count", nfill, exp_fill);
        chk(tag, "write count", nwr, exp_wr);
        if (exp_wr == 1) begin
            chk(tag, "write data", wd, exp_wd);
            chk(tag, "write mask", {28'b0, wm}, {28'b0, exp_wm});
        end
        if (exp_fill == 1 && exp_wr == 1)
            chk("R3", "fill before write-back", {31'b0, fill_at < wr_at}, 32'd1);
        chk(tag, "valid", {31'b0, line_valid}, {31'b0, nv});
        chk(tag, "modified", {31'b0, line_mod}, {31'b0, nm});
        if (nv) chk(tag, "line data", line_data, nd);
        @(negedge clk);
        chk("R11", "done single pulse", {31'b0, done}, 32'd0);
        mv = nv; mm = nm; md = nd;
    endtask

    // bring the line to state ps: 0 invalid, 1 clean, 2 modified
    task automatic setup(input int ps, input logic [1:0] idx);
        run_cmd(2'd2, 1'b1, 1'b0, 2'd0, 8'h00, 0);
        if (ps >= 1) run_cmd(2'd0, 1'b1, 1'b0, idx ^ 2'd1, 8'(tnum * 29 + 7), 1);
        if (ps == 1) run_cmd(2'd3, 1'b1, 1'b1, 2'd0, 8'h00, 0);
    endtask

    task automatic summary;
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", ncmp, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        ncmp++; nbad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "reset valid", {31'b0, line_valid}, 32'd0);
        chk("R1", "reset modified", {31'b0, line_mod}, 32'd0);
        chk("R1", "reset busy", {31'b0, busy}, 32'd0);
        chk("R1", "reset done", {31'b0, done}, 32'd0);
        chk("R1", "reset err", {31'b0, err}, 32'd0);
        chk("R1", "reset requests", {30'b0, fill_req, mem_wr_valid}, 32'd0);
        rst_n = 1;
        for (int ps = 0; ps < 3; ps++)
            for (int op = 0; op < 4; op++)
                for (int cb = 0; cb < 2; cb++)
                    for (int kp = 0; kp < 2; kp++)
                        for (int ix = 0; ix < 4; ix++) begin
                            setup(ps, 2'(ix));
                            run_cmd(2'(op), cb[0], kp[0], 2'(ix),
                                    8'(tnum * 13 + 91), tnum % 3);
                            if (line_mod && !line_valid)
                                chk("R1", "encoding", 32'd1, 32'd0);
                        end
        summary();
    end
endmodule